// File: doc/BRIEF.md
# Sixteen-Bit ALU with Condition Flag Register

This block is the integer datapath of a small processor core. It takes two operands, a four-bit operation code and a size select. It forms the result combinationally in the same cycle. When the operation is strobed, it loads a set of condition flags into a sixteen-bit flag word. The operations are addition, subtraction, the three bitwise logic functions, increment, decrement, one's complement and three single-position shifts. Each can run on the full sixteen-bit word or on the low byte alone.

Each operation class updates only the flags that belong to it. The other flags keep their stored value. The flags are:

- sign
- zero
- even parity of the low result byte
- carry or borrow at the top of the selected width
- nibble carry or borrow at the bit 3 / bit 4 boundary
- signed overflow

Three control bits share the flag word: single-step trap, interrupt enable and string direction. They change only through a separate write strobe, never as a side effect of an operation. The surrounding core reads the packed flag word to evaluate branch conditions and to save processor state.

Top module: `alu_flags_unit`

## Requirements
- R1: Opcode 0 (add) returns opa+opb truncated to the selected width. Carry is set on a carry out of the top bit of that width. Overflow is set when both operands share a sign bit and the result's sign bit differs.
- R2: Opcode 1 (subtract) returns opa-opb. Carry is set when a borrow is taken from beyond the top bit. Overflow is set when the operand signs differ and the result's sign differs from opa's sign.
- R3: For add, subtract, increment and decrement, the auxiliary flag is set on a carry out of, or a borrow into, bit 3 (between the low nibble and bit 4).
- R4: Parity is set exactly when result bits 7..0 hold an even number of ones, in both byte and word mode. Every operation except complement updates it.
- R5: Zero is set when the result of the selected width is all zeros. Sign copies the top bit of that width (bit 15 for a word, bit 7 for a byte).
- R6: Opcodes 2 (AND), 3 (OR) and 4 (XOR) return the bitwise function of the operands. They clear carry, overflow and auxiliary.
- R7: Opcodes 5 (increment) and 6 (decrement) return opa+1 and opa-1, and opb is ignored. Carry keeps its previous value. Auxiliary, overflow, parity, zero and sign are updated as for add and subtract with a second operand of one.
- R8: Opcode 7 (complement) returns the bitwise inverse of opa and leaves every flag unchanged.
- R9: Opcodes 8 (shift left), 9 (logical shift right) and 10 (arithmetic shift right) move the operand one position. Carry gets the bit shifted out. Overflow is the new sign XOR carry for the left shift, the original sign bit for the logical right shift, and 0 for the arithmetic right shift. Auxiliary is cleared.
- R10: With byte_mode high, only opa[7:0] and opb[7:0] take part, and result[15:8] reads zero.
- R11: The flag word places carry at bit 0, parity at 2, auxiliary at 4, zero at 6, sign at 7, trap at 8, interrupt enable at 9, direction at 10 and overflow at 11. Bit 1 and bits 15..12 read one, and bits 3 and 5 read zero. After reset the word is 16'hF002.
- R12: The status flags change only at a clock edge with op_valid high. The trap, interrupt and direction bits change only at a clock edge with ctl_wr high, and then take ctl_trap, ctl_intr and ctl_dir.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Strobe: load status flags from the current operation |
| op_code | input | 4 | Operation select (0 to 10) |
| byte_mode | input | 1 | 1 = operate on the low byte, 0 = full word |
| opa | input | 16 | First operand |
| opb | input | 16 | Second operand |
| ctl_wr | input | 1 | Strobe: load the three control bits |
| ctl_dir | input | 1 | New direction bit |
| ctl_intr | input | 1 | New interrupt-enable bit |
| ctl_trap | input | 1 | New single-step trap bit |
| result | output | 16 | Combinational operation result |
| flags | output | 16 | Registered packed flag word |

## Verification
Assertions watch several rules on every cycle of any stimulus. Parity and zero must match the result strobed in the previous cycle. Logic operations must leave carry, overflow and auxiliary clear. Increment and decrement must keep carry, and complement must keep the whole word. The status bits and the control bits must hold whenever their strobes are low. The numeric content of carry, overflow and auxiliary at the width boundaries is shown only by the bench's directed scenarios. The same holds for byte-mode truncation, the three shift variants and the exact placement of bits in the flag word, which the bench compares against hand-derived values.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_AND = 4'd2,
    OP_OR  = 4'd3,
    OP_XOR = 4'd4,
    OP_INC = 4'd5,
    OP_DEC = 4'd6,
    OP_NOT = 4'd7,
    OP_SHL = 4'd8,
    OP_SHR = 4'd9,
    OP_SAR = 4'd10
  } alu_op_e;

  typedef enum logic [1:0] {
    SH_LEFT    = 2'd0,
    SH_LOGIC_R = 2'd1,
    SH_ARITH_R = 2'd2
  } shift_e;

  typedef struct packed {
    logic ovf;
    logic sgn;
    logic zro;
    logic aux;
    logic par;
    logic cry;
  } stat_t;

  typedef struct packed {
    logic trap;
    logic intr;
    logic dir;
  } ctl_t;

  localparam int FLAG_W   = 16;
  localparam int POS_CRY  = 0;
  localparam int POS_PAR  = 2;
  localparam int POS_AUX  = 4;
  localparam int POS_ZRO  = 6;
  localparam int POS_SGN  = 7;
  localparam int POS_TRAP = 8;
  localparam int POS_INTR = 9;
  localparam int POS_DIR  = 10;
  localparam int POS_OVF  = 11;
  localparam logic [FLAG_W-1:0] FIXED_PATTERN = 16'hF002;

  function automatic logic [FLAG_W-1:0] pack_flags(stat_t s, ctl_t c);
    logic [FLAG_W-1:0] w;
    w           = FIXED_PATTERN;
    w[POS_CRY]  = s.cry;
    w[POS_PAR]  = s.par;
    w[POS_AUX]  = s.aux;
    w[POS_ZRO]  = s.zro;
    w[POS_SGN]  = s.sgn;
    w[POS_OVF]  = s.ovf;
    w[POS_TRAP] = c.trap;
    w[POS_INTR] = c.intr;
    w[POS_DIR]  = c.dir;
    return w;
  endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] r,
  output logic         cout,
  output logic         aux,
  output logic         ovf
);
  localparam int NIB = 4;

  logic [W:0] ext;

  always_comb begin
    if (sub) ext = {1'b0, a} - {1'b0, b};
    else     ext = {1'b0, a} + {1'b0, b};
  end

  assign r    = ext[W-1:0];
  assign cout = ext[W];
  // carry or borrow across the nibble boundary shows up as a flipped bit 4
  assign aux  = a[NIB] ^ b[NIB] ^ r[NIB];

  always_comb begin
    if (sub) ovf = (a[W-1] != b[W-1]) && (r[W-1] != a[W-1]);
    else     ovf = (a[W-1] == b[W-1]) && (r[W-1] != a[W-1]);
  end

  initial begin
    assert (W > NIB) else $error("alu_addsub width too small");
  end
endmodule

// File: rtl/alu_shift1.sv
module alu_shift1
  import alu_flags_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  shift_e       mode,
  output logic [W-1:0] r,
  output logic         cout,
  output logic         ovf
);
  always_comb begin
    case (mode)
      SH_LEFT: begin
        r    = {a[W-2:0], 1'b0};
        cout = a[W-1];
        ovf  = a[W-2] ^ a[W-1];
      end
      SH_LOGIC_R: begin
        r    = {1'b0, a[W-1:1]};
        cout = a[0];
        ovf  = a[W-1];
      end
      SH_ARITH_R: begin
        r    = {a[W-1], a[W-1:1]};
        cout = a[0];
        ovf  = 1'b0;
      end
      default: begin
        r    = a;
        cout = 1'b0;
        ovf  = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
  import alu_flags_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  stat_t             st_new,
  input  stat_t             st_upd,
  input  logic              ctl_wr,
  input  ctl_t              ctl_new,
  output logic [FLAG_W-1:0] flags
);
  stat_t st_q, st_d;
  ctl_t  ctl_q, ctl_d;

  always_comb begin
    st_d  = stat_t'((st_q & ~st_upd) | (st_new & st_upd));
    ctl_d = ctl_new;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= '0;
      ctl_q <= '0;
    end else begin
      if (op_valid) st_q  <= st_d;
      if (ctl_wr)   ctl_q <= ctl_d;
    end
  end

  assign flags = pack_flags(st_q, ctl_q);

  // R12: control bits move only under their own strobe
  p_ctl_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr |=> $stable({flags[POS_TRAP], flags[POS_INTR], flags[POS_DIR]}));

  // R12: status bits move only when an operation is strobed
  p_stat_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable({flags[POS_OVF], flags[POS_SGN], flags[POS_ZRO],
                           flags[POS_AUX], flags[POS_PAR], flags[POS_CRY]}));

  // R12: a control write lands on the requested values
  p_ctl_load_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> (flags[POS_DIR] == $past(ctl_new.dir)) &&
               (flags[POS_INTR] == $past(ctl_new.intr)));
endmodule

// File: rtl/alu_flags_unit.sv
module alu_flags_unit
  import alu_flags_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [3:0]        op_code,
  input  logic              byte_mode,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic              ctl_wr,
  input  logic              ctl_dir,
  input  logic              ctl_intr,
  input  logic              ctl_trap,
  output logic [DATA_W-1:0] result,
  output logic [FLAG_W-1:0] flags
);
  localparam int HI_W = DATA_W - LANE_W;
  localparam logic [DATA_W-1:0] LANE_MASK = {{HI_W{1'b0}}, {LANE_W{1'b1}}};
  localparam logic [DATA_W-1:0] ONE_W     = {{(DATA_W-1){1'b0}}, 1'b1};

  alu_op_e op;
  assign op = alu_op_e'(op_code);

  // operand shaping shared by both widths
  logic              is_step, is_sub;
  logic [DATA_W-1:0] b_eff;
  shift_e            sh_mode;

  always_comb begin
    is_step = (op == OP_INC) || (op == OP_DEC);
    is_sub  = (op == OP_SUB) || (op == OP_DEC);
    b_eff   = is_step ? ONE_W : opb;
    case (op)
      OP_SHR:  sh_mode = SH_LOGIC_R;
      OP_SAR:  sh_mode = SH_ARITH_R;
      default: sh_mode = SH_LEFT;
    endcase
  end

  // word-width arithmetic and shift
  logic [DATA_W-1:0] aw_r, sw_r;
  logic              aw_c, aw_a, aw_o, sw_c, sw_o;

  alu_addsub #(.W(DATA_W)) u_add_word (
    .a(opa), .b(b_eff), .sub(is_sub),
    .r(aw_r), .cout(aw_c), .aux(aw_a), .ovf(aw_o)
  );

  alu_shift1 #(.W(DATA_W)) u_shift_word (
    .a(opa), .mode(sh_mode), .r(sw_r), .cout(sw_c), .ovf(sw_o)
  );

  // lane-width arithmetic and shift
  logic [LANE_W-1:0] al_r, sl_r;
  logic              al_c, al_a, al_o, sl_c, sl_o;

  alu_addsub #(.W(LANE_W)) u_add_lane (
    .a(opa[LANE_W-1:0]), .b(b_eff[LANE_W-1:0]), .sub(is_sub),
    .r(al_r), .cout(al_c), .aux(al_a), .ovf(al_o)
  );

  alu_shift1 #(.W(LANE_W)) u_shift_lane (
    .a(opa[LANE_W-1:0]), .mode(sh_mode), .r(sl_r), .cout(sl_c), .ovf(sl_o)
  );

  // result select and per-class flag update mask
  logic [DATA_W-1:0] res;
  logic [DATA_W-1:0] size_mask;
  stat_t             st_new, st_upd;

  always_comb begin
    size_mask = byte_mode ? LANE_MASK : '1;
    res       = '0;
    st_new    = '0;
    st_upd    = '0;
    case (op)
      OP_ADD, OP_SUB, OP_INC, OP_DEC: begin
        res        = byte_mode ? {{HI_W{1'b0}}, al_r} : aw_r;
        st_new.cry = byte_mode ? al_c : aw_c;
        st_new.aux = byte_mode ? al_a : aw_a;
        st_new.ovf = byte_mode ? al_o : aw_o;
        st_upd     = '1;
        st_upd.cry = !is_step;
      end
      OP_AND: begin
        res    = (opa & opb) & size_mask;
        st_upd = '1;
      end
      OP_OR: begin
        res    = (opa | opb) & size_mask;
        st_upd = '1;
      end
      OP_XOR: begin
        res    = (opa ^ opb) & size_mask;
        st_upd = '1;
      end
      OP_NOT: begin
        res = ~opa & size_mask;
      end
      OP_SHL, OP_SHR, OP_SAR: begin
        res        = byte_mode ? {{HI_W{1'b0}}, sl_r} : sw_r;
        st_new.cry = byte_mode ? sl_c : sw_c;
        st_new.ovf = byte_mode ? sl_o : sw_o;
        st_upd     = '1;
      end
      default: begin
        res = '0;
      end
    endcase
    st_new.zro = (res == '0);
    st_new.sgn = byte_mode ? res[LANE_W-1] : res[DATA_W-1];
    st_new.par = ~^res[LANE_W-1:0];
  end

  assign result = res;

  ctl_t ctl_new;
  assign ctl_new = '{trap: ctl_trap, intr: ctl_intr, dir: ctl_dir};

  alu_flag_reg u_flags (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid),
    .st_new(st_new), .st_upd(st_upd),
    .ctl_wr(ctl_wr), .ctl_new(ctl_new), .flags(flags)
  );

  // R4: stored parity matches the low byte of the strobed result
  p_parity_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code <= 4'd10 && op_code != 4'd7)
      |=> flags[POS_PAR] == ~^$past(result[LANE_W-1:0]));

  // R5: stored zero flag matches the strobed result
  p_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code <= 4'd10 && op_code != 4'd7)
      |=> flags[POS_ZRO] == ($past(result) == '0));

  // R6: logic operations leave carry, overflow and auxiliary clear
  p_logic_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code >= 4'd2 && op_code <= 4'd4)
      |=> !flags[POS_CRY] && !flags[POS_OVF] && !flags[POS_AUX]);

  // R7: increment and decrement keep carry
  p_step_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_code == 4'd5 || op_code == 4'd6))
      |=> flags[POS_CRY] == $past(flags[POS_CRY]));

  // R8: complement changes no flag
  p_not_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 4'd7 && !ctl_wr) |=> $stable(flags));

  // R10: byte results never carry into the upper byte
  p_byte_upper_r10: assert property (@(posedge clk) disable iff (!rst_n)
    byte_mode |-> result[DATA_W-1:LANE_W] == '0);
endmodule

// File: tb/alu_flags_unit_test.sv
module alu_flags_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [3:0]  op_code;
  logic        byte_mode;
  logic [15:0] opa, opb;
  logic        ctl_wr, ctl_dir, ctl_intr, ctl_trap;
  logic [15:0] result, flags;

  int checks = 0;
  int errors = 0;
  logic e_tf = 1'b0, e_if = 1'b0, e_df = 1'b0;

  always #4 clk = ~clk;

  alu_flags_unit uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .byte_mode(byte_mode), .opa(opa), .opb(opb), .ctl_wr(ctl_wr),
    .ctl_dir(ctl_dir), .ctl_intr(ctl_intr), .ctl_trap(ctl_trap),
    .result(result), .flags(flags)
  );

  function automatic logic [15:0] fw(input logic cf, pf, af, zf, sf, of);
    logic [15:0] w;
    w = 16'hF002;
    w[0] = cf; w[2] = pf; w[4] = af; w[6] = zf; w[7] = sf; w[11] = of;
    w[8] = e_tf; w[9] = e_if; w[10] = e_df;
    return w;
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one strobed operation, check result mid-cycle and flags after the edge
  task automatic run_op(input string tag, input logic [3:0] opc, input logic bm,
                        input logic [15:0] a, input logic [15:0] b,
                        input logic [15:0] exp_res, input logic [15:0] exp_flags);
    @(negedge clk);
    op_code = opc; byte_mode = bm; opa = a; opb = b; op_valid = 1'b1;
    #1;
    check({tag, " result"}, result, exp_res);
    @(negedge clk);
    op_valid = 1'b0;
    check({tag, " flags"}, flags, exp_flags);
  endtask

  task automatic t_reset;
    check("R11 reset flag word", flags, 16'hF002);
    check("R11 reset via model", flags, fw(0,0,0,0,0,0));
  endtask

  task automatic t_add;
    run_op("R1 R3 add signed overflow", 4'd0, 1'b0, 16'h7FFF, 16'h0001, 16'h8000, fw(0,1,1,0,1,1));
    run_op("R1 R5 add wraps to zero",   4'd0, 1'b0, 16'hFFFF, 16'h0001, 16'h0000, fw(1,1,1,1,0,0));
    run_op("R1 add carry and overflow", 4'd0, 1'b0, 16'h8000, 16'h8000, 16'h0000, fw(1,1,0,1,0,1));
  endtask

  task automatic t_sub;
    run_op("R2 R3 sub borrow",          4'd1, 1'b0, 16'h0000, 16'h0001, 16'hFFFF, fw(1,1,1,0,1,0));
    run_op("R2 sub signed overflow",    4'd1, 1'b0, 16'h8000, 16'h0001, 16'h7FFF, fw(0,1,1,0,0,1));
  endtask

  task automatic t_byte;
    run_op("R10 byte add carry",        4'd0, 1'b1, 16'h12F0, 16'h3410, 16'h0000, fw(1,1,0,1,0,0));
    run_op("R10 R5 byte add overflow",  4'd0, 1'b1, 16'h0040, 16'h0040, 16'h0080, fw(0,0,0,0,1,1));
    run_op("R10 byte sub borrow",       4'd1, 1'b1, 16'hAB10, 16'hCD20, 16'h00F0, fw(1,1,0,0,1,0));
  endtask

  task automatic t_logic;
    run_op("R1 prime carry/overflow",   4'd0, 1'b0, 16'h8000, 16'h8000, 16'h0000, fw(1,1,0,1,0,1));
    run_op("R6 and clears",             4'd2, 1'b0, 16'hF0F0, 16'h0FFF, 16'h00F0, fw(0,1,0,0,0,0));
    run_op("R6 or",                     4'd3, 1'b0, 16'h8001, 16'h0002, 16'h8003, fw(0,1,0,0,1,0));
    run_op("R6 xor to zero",            4'd4, 1'b0, 16'hAAAA, 16'hAAAA, 16'h0000, fw(0,1,0,1,0,0));
  endtask

  task automatic t_step;
    run_op("R1 prime carry set",        4'd0, 1'b0, 16'hFFFF, 16'h0001, 16'h0000, fw(1,1,1,1,0,0));
    run_op("R7 R3 inc keeps carry",     4'd5, 1'b0, 16'h000F, 16'h1234, 16'h0010, fw(1,0,1,0,0,0));
    run_op("R7 dec overflow",           4'd6, 1'b0, 16'h8000, 16'hFFFF, 16'h7FFF, fw(1,1,1,0,0,1));
    run_op("R2 prime carry clear",      4'd1, 1'b0, 16'h8000, 16'h0001, 16'h7FFF, fw(0,1,1,0,0,1));
    run_op("R7 inc wraps, carry kept",  4'd5, 1'b0, 16'hFFFF, 16'h5555, 16'h0000, fw(0,1,1,1,0,0));
  endtask

  task automatic t_not;
    run_op("R8 not word, flags kept",   4'd7, 1'b0, 16'h00FF, 16'h0000, 16'hFF00, fw(0,1,1,1,0,0));
    run_op("R8 R10 not byte",           4'd7, 1'b1, 16'h1234, 16'h0000, 16'h00CB, fw(0,1,1,1,0,0));
  endtask

  task automatic t_shift;
    run_op("R9 shl carry out",          4'd8,  1'b0, 16'hC001, 16'h0000, 16'h8002, fw(1,0,0,0,1,0));
    run_op("R9 shl overflow",           4'd8,  1'b0, 16'h4000, 16'h0000, 16'h8000, fw(0,1,0,0,1,1));
    run_op("R9 shr",                    4'd9,  1'b0, 16'h8001, 16'h0000, 16'h4000, fw(1,1,0,0,0,1));
    run_op("R9 sar",                    4'd10, 1'b0, 16'h8001, 16'h0000, 16'hC000, fw(1,1,0,0,1,0));
    run_op("R9 R10 byte shr",           4'd9,  1'b1, 16'hFF81, 16'h0000, 16'h0040, fw(1,0,0,0,0,1));
    run_op("R9 R10 byte shl",           4'd8,  1'b1, 16'h0080, 16'h0000, 16'h0000, fw(1,1,0,1,0,1));
  endtask

  task automatic t_parity;
    run_op("R4 parity low byte only",   4'd0, 1'b0, 16'h0300, 16'h0000, 16'h0300, fw(0,1,0,0,0,0));
    run_op("R4 odd low byte",           4'd0, 1'b0, 16'h0001, 16'h0100, 16'h0101, fw(0,0,0,0,0,0));
  endtask

  task automatic t_control;
    run_op("R1 prime small add",        4'd0, 1'b0, 16'h0001, 16'h0001, 16'h0002, fw(0,0,0,0,0,0));
    @(negedge clk);
    ctl_wr = 1'b1; ctl_dir = 1'b1; ctl_intr = 1'b1; ctl_trap = 1'b0;
    @(negedge clk);
    ctl_wr = 1'b0;
    e_df = 1'b1; e_if = 1'b1; e_tf = 1'b0;
    check("R12 R11 control write", flags, 16'hF602);
    ctl_dir = 1'b0; ctl_intr = 1'b0; ctl_trap = 1'b1;
    run_op("R12 op keeps control",      4'd4, 1'b0, 16'h000F, 16'h000F, 16'h0000, fw(0,1,0,1,0,0));
    @(negedge clk);
    op_code = 4'd0; opa = 16'hFFFF; opb = 16'h0001; op_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R12 idle keeps flags", flags, fw(0,1,0,1,0,0));
  endtask

  initial begin
    #100000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; op_code = 4'd0; byte_mode = 1'b0;
    opa = '0; opb = '0; ctl_wr = 1'b0; ctl_dir = 1'b0; ctl_intr = 1'b0; ctl_trap = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_add;
    t_sub;
    t_byte;
    t_logic;
    t_step;
    t_not;
    t_shift;
    t_parity;
    t_control;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule